// File: doc/BRIEF.md
# Base and Limit Address Relocation Unit

This unit sits between a processor's address generation and the memory side. It holds two registers per running process. The relocation register gives the physical start of the process image. The bound register gives the largest offset from zero that the process may use, which makes it a length rather than an end address. Every request carries a logical address and a write flag. The unit first compares the logical address with the bound, before any addition. If the address is inside the bound, the unit adds the relocation value and forwards the physical address. If it is outside, the unit raises a protection fault and issues nothing to memory.

A context switch is modelled by two privileged register writes, one to each register. A write attempted outside privileged mode does not change either register, and it raises a separate privilege-error flag for one cycle. A sum that does not fit in the physical address width is also treated as a protection fault. Each request is answered exactly one cycle later, either by a forwarded memory request or by a fault.

Top module: `reloc_unit`

## Requirements
- R1: A request whose logical address is less than or equal to the bound register is forwarded. A request whose address is greater than the bound is refused.
- R2: A refused request raises `fault_o` for one cycle and leaves `mem_valid_o` low in that cycle.
- R3: A forwarded request presents `mem_addr_o` = logical address + relocation register, and `mem_wr_o` equals the request's write flag.
- R4: The bound is compared with the unrelocated address. With a nonzero relocation value, a logical address equal to the bound is still forwarded.
- R5: A configuration write while `priv_i` is low leaves both registers unchanged.
- R6: A configuration write while `priv_i` is low sets `priv_err_o` in the following cycle. A privileged write does not set it. `priv_err_o` never drives `fault_o`.
- R7: A request whose sum does not fit in PA_W bits raises `fault_o` even when it is inside the bound.
- R8: Each request gets exactly one response in the next cycle: either `mem_valid_o` or `fault_o`, never both. With no request, both stay low.
- R9: After reset, the relocation register is 0, the bound register is all ones, and all outputs are low.
- R10: When a privileged write and a request fall in the same cycle, the request is judged against the register values held before that write. The next request sees the new values.
- R11: `cfg_sel_i` = 0 selects the relocation register and `cfg_sel_i` = 1 selects the bound register. The bound register takes the low LA_W bits of `cfg_data_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | Processor is in privileged mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Register select: 0 relocation, 1 bound |
| cfg_data_i | input | PA_W | Configuration write data |
| req_valid_i | input | 1 | Request present this cycle |
| req_wr_i | input | 1 | Request is a write |
| req_addr_i | input | LA_W | Logical address |
| mem_valid_o | output | 1 | Forwarded memory request |
| mem_wr_o | output | 1 | Write flag of the forwarded request |
| mem_addr_o | output | PA_W | Physical address |
| fault_o | output | 1 | Protection fault for the previous request |
| priv_err_o | output | 1 | Unprivileged configuration write was refused |

## Verification
Two functions can fall in the same cycle: a register reload and a translated request. The bench provokes this by driving a privileged relocation write together with a request in one cycle. It judges the result by requiring that the response carry the old relocation value, and that the request which follows carry the new one. A second overlap is a refused user-mode write issued alongside an out-of-bound request. Here the privilege error and the protection fault must each appear on their own flag in the same response cycle, with no memory request issued.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic {
    SEL_RELOC = 1'b0,
    SEL_BOUND = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
  import reloc_pkg::*;
#(
  parameter int LA_W = 8,
  parameter int PA_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            priv_i,
  input  logic            cfg_we_i,
  input  logic            cfg_sel_i,
  input  logic [PA_W-1:0] cfg_data_i,
  output logic [PA_W-1:0] reloc_o,
  output logic [LA_W-1:0] bound_o,
  output logic            priv_err_o
);
  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      reloc_o    <= '0;
      bound_o    <= '1;
      priv_err_o <= 1'b0;
    end else begin
      priv_err_o <= cfg_we_i & ~priv_i;
      if (cfg_we_i && priv_i) begin
        if (sel == SEL_RELOC) reloc_o <= cfg_data_i;
        else                  bound_o <= cfg_data_i[LA_W-1:0];
      end
    end
  end

  AST_USER_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && !priv_i) |=> ($stable(reloc_o) && $stable(bound_o))); // R5
  AST_USER_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && !priv_i) |=> priv_err_o); // R6
  AST_PRIV_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && priv_i) |=> !priv_err_o); // R6
endmodule

// File: rtl/reloc_check.sv
module reloc_check #(
  parameter int LA_W = 8,
  parameter int PA_W = 10
) (
  input  logic [LA_W-1:0] laddr_i,
  input  logic [PA_W-1:0] reloc_i,
  input  logic [LA_W-1:0] bound_i,
  output logic            grant_o,
  output logic [PA_W-1:0] paddr_o
);
  localparam int SUM_W = PA_W + 1;

  logic [SUM_W-1:0] addr_ext;
  logic [SUM_W-1:0] sum;
  logic             in_bound;
  logic             carry;

  always_comb begin
    addr_ext = SUM_W'(laddr_i);
    sum      = addr_ext + SUM_W'(reloc_i);
    carry    = sum[PA_W];
    in_bound = (laddr_i <= bound_i);
    grant_o  = in_bound & ~carry;
    paddr_o  = sum[PA_W-1:0];
  end
endmodule

// File: rtl/reloc_unit.sv
module reloc_unit #(
  parameter int LA_W = 8,
  parameter int PA_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            priv_i,
  input  logic            cfg_we_i,
  input  logic            cfg_sel_i,
  input  logic [PA_W-1:0] cfg_data_i,
  input  logic            req_valid_i,
  input  logic            req_wr_i,
  input  logic [LA_W-1:0] req_addr_i,
  output logic            mem_valid_o,
  output logic            mem_wr_o,
  output logic [PA_W-1:0] mem_addr_o,
  output logic            fault_o,
  output logic            priv_err_o
);
  logic [PA_W-1:0] reloc_q;
  logic [LA_W-1:0] bound_q;
  logic            grant;
  logic [PA_W-1:0] paddr;

  reloc_regs #(.LA_W(LA_W), .PA_W(PA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .priv_i     (priv_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_data_i (cfg_data_i),
    .reloc_o    (reloc_q),
    .bound_o    (bound_q),
    .priv_err_o (priv_err_o)
  );

  reloc_check #(.LA_W(LA_W), .PA_W(PA_W)) u_check (
    .laddr_i (req_addr_i),
    .reloc_i (reloc_q),
    .bound_i (bound_q),
    .grant_o (grant),
    .paddr_o (paddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid_o <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_addr_o  <= '0;
      fault_o     <= 1'b0;
    end else begin
      mem_valid_o <= req_valid_i & grant;
      fault_o     <= req_valid_i & ~grant;
      if (req_valid_i && grant) begin
        mem_addr_o <= paddr;
        mem_wr_o   <= req_wr_i;
      end
    end
  end

  AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid_o && fault_o)); // R8
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> (mem_valid_o || fault_o)); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> (!mem_valid_o && !fault_o)); // R8
  AST_BOUND_HONOURED: assert property (@(posedge clk) disable iff (rst)
    mem_valid_o |-> ($past(req_addr_i) <= $past(bound_q))); // R1
  AST_RELOCATED: assert property (@(posedge clk) disable iff (rst)
    mem_valid_o |-> (mem_addr_o == PA_W'($past(req_addr_i)) + $past(reloc_q))); // R3
endmodule

// File: tb/reloc_unit_bench.sv
module reloc_unit_bench;
  localparam int LA_W = 8;
  localparam int PA_W = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            priv_i = 1'b0;
  logic            cfg_we_i = 1'b0;
  logic            cfg_sel_i = 1'b0;
  logic [PA_W-1:0] cfg_data_i = '0;
  logic            req_valid_i = 1'b0;
  logic            req_wr_i = 1'b0;
  logic [LA_W-1:0] req_addr_i = '0;
  logic            mem_valid_o, mem_wr_o, fault_o, priv_err_o;
  logic [PA_W-1:0] mem_addr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  reloc_unit #(.LA_W(LA_W), .PA_W(PA_W)) u_reloc_unit (
    .clk(clk), .rst(rst), .priv_i(priv_i), .cfg_we_i(cfg_we_i),
    .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
    .req_valid_i(req_valid_i), .req_wr_i(req_wr_i), .req_addr_i(req_addr_i),
    .mem_valid_o(mem_valid_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
    .fault_o(fault_o), .priv_err_o(priv_err_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; outputs sampled 1 ns after the capturing edge.
  task automatic step(input bit rv, input bit wr, input int addr,
                      input bit we, input bit pv, input bit sel, input int data);
    @(negedge clk);
    req_valid_i = rv; req_wr_i = wr; req_addr_i = LA_W'(addr);
    cfg_we_i = we; priv_i = pv; cfg_sel_i = sel; cfg_data_i = PA_W'(data);
    @(posedge clk);
    #1;
    @(negedge clk);
    req_valid_i = 1'b0; cfg_we_i = 1'b0; priv_i = 1'b0;
  endtask

  task automatic load(input int rel, input int bnd);
    step(0, 0, 0, 1, 1, 0, rel);
    step(0, 0, 0, 1, 1, 1, bnd);
  endtask

  // Expected response computed from the requirements
  task automatic expect_req(input string req, input int addr, input bit wr,
                            input int rel, input int bnd);
    bit ok;
    ok = (addr <= bnd) && (addr + rel < (1 << PA_W));
    step(1, wr, addr, 0, 0, 0, 0);
    chk(req, {mem_valid_o, fault_o}, ok ? 2'b10 : 2'b01);
    if (ok) begin
      chk({req, " addr"}, int'(mem_addr_o), addr + rel);
      chk({req, " wr"}, int'(mem_wr_o), int'(wr));
    end
  endtask

  task automatic sweep(input string req, input int rel, input int bnd);
    for (int a = 0; a < (1 << LA_W); a++) expect_req(req, a, a[0], rel, bnd);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset outputs", {mem_valid_o, fault_o, priv_err_o}, 0);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset values reloc 0, bound all ones -> everything forwarded
    sweep("R9 reset regs", 0, 255);
    // R8: idle cycle gives no response
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R8 idle", {mem_valid_o, fault_o}, 0);
    // R1 R2 R3 R4: nonzero reloc, partial bound (addr == bound forwarded)
    load('h3f, 'h80);
    sweep("R1 R2 R3 R4 bound", 'h3f, 'h80);
    // R7: sum overflows PA_W for addr >= 0x40
    load('h3c0, 'hff);
    sweep("R7 overflow", 'h3c0, 'hff);
    // R1 bound zero: only address 0 forwarded
    load('h200, 'h0);
    sweep("R1 bound zero", 'h200, 'h0);
    // R11: bound takes low LA_W bits of data
    load('h10, 'h37f);
    expect_req("R11 bound low bits", 'h7f, 1, 'h10, 'h7f);
    expect_req("R11 bound low bits", 'h80, 0, 'h10, 'h7f);
    // R5 R6: user-mode writes refused and flagged
    step(0, 0, 0, 1, 0, 0, 'h155);
    chk("R6 user reloc write flag", priv_err_o, 1);
    step(0, 0, 0, 1, 0, 1, 'h05);
    chk("R6 user bound write flag", priv_err_o, 1);
    expect_req("R5 regs kept", 'h7f, 0, 'h10, 'h7f);
    expect_req("R5 regs kept", 'h06, 1, 'h10, 'h7f);
    chk("R6 flag one cycle", priv_err_o, 0);
    // R6: privileged write raises no flag
    step(0, 0, 0, 1, 1, 0, 'h20);
    chk("R6 priv write quiet", priv_err_o, 0);
    // R10: privileged write plus request in one cycle uses old reloc 0x20
    step(1, 1, 'h05, 1, 1, 0, 'h100);
    chk("R10 old values", {mem_valid_o, fault_o}, 2'b10);
    chk("R10 old reloc", int'(mem_addr_o), 'h25);
    expect_req("R10 new reloc", 'h05, 1, 'h100, 'h7f);
    // R6 R2: user write plus out-of-bound request, separate flags
    step(1, 0, 'h90, 1, 0, 1, 'hff);
    chk("R6 R2 both flags", {mem_valid_o, fault_o, priv_err_o}, 3'b011);
    expect_req("R5 bound kept", 'h90, 0, 'h100, 'h7f);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule